// File: doc/BRIEF.md
# Three-Wire Synthesiser Control Interface

This block takes a 26-bit programming word from a three-wire serial bus with data, clock and enable lines, and turns it into the control fields of a frequency synthesiser. The three bus lines are asynchronous to the block. They are brought into the system clock domain, and their edges are detected there. While enable is high, each rising edge of the bus clock shifts one data bit into a holding register. When enable falls, the word is committed to the control registers, provided exactly 26 bits arrived in that window. Otherwise the word is thrown away.

The committed word supplies several outputs. It gives a 17-bit divider ratio, which is offered to the divider as a pending value with a one-cycle load strobe. It also gives a 4-bit reference-divider code, a 2-bit charge-pump current code, and the drive for two open-drain switching ports. A test bit changes the meaning of the two port bits. In test mode they either force the charge pump to sink, source or switch off, or they route two observed test signals onto the ports.

A state machine in `word_rx` handles reception. It has four states:
- S_IDLE: enable is low and bus clocks are ignored. It moves to S_SHIFT when enable is seen high.
- S_SHIFT: it counts and shifts bits. On the falling edge of enable it moves to S_COMMIT if the count is exactly 26, and to S_DROP otherwise.
- S_COMMIT and S_DROP: each lasts one cycle and then returns to S_IDLE.

Top module: `synth_ctrl_if`

## Requirements
- R1: The word is sent most significant bit first. Bit 25 (first sent) is P1, bit 24 is P0, bit 23 is the test bit, bits 22:21 are the current code, bits 20:17 are the reference code and bits 16:0 are the divider ratio. After a commit, `ratio_pend` = bits 16:0 and `ref_sel` = bits 20:17, in which ref_sel[3:1] carry the three ratio bits and ref_sel[0] the reference mode bit.
- R2: Bus clock edges while enable is low shift nothing and change no output. No `ratio_load` occurs.
- R3: Outputs change only after enable falls. While enable is still high after 26 bits, all outputs keep their previous values.
- R4: A window containing fewer or more than 26 clock edges is discarded. No `ratio_load` occurs and every output keeps its previous value.
- R5: Each accepted word raises `ratio_load` for exactly one system clock cycle. The new `ratio_pend` is valid in that same cycle.
- R6: With the test bit 0, `port1_on` = P1, `port0_on` = P0, and `pump_mode` = 00 (normal). A port output of 1 means the open-drain port sinks current (on).
- R7: With the test bit 1, {P1,P0} = 00 gives `pump_mode` = 01 (forced sink). The value 01 gives `pump_mode` = 10 (forced source), and 10 gives `pump_mode` = 11 (pump off). In these three cases both ports are 0.
- R8: With the test bit 1 and {P1,P0} = 11, `port1_on` follows `fcomp_in` and `port0_on` follows `divh_in` without a register, and `pump_mode` = 00.
- R9: `pump_cur` equals word bits 22:21 of the last accepted word.
- R10: After reset, every output is 0. This means both ports are off, the pump mode is normal and `ratio_load` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_data | input | 1 | Serial data line (asynchronous) |
| bus_clk | input | 1 | Serial clock line, rising edge samples (asynchronous) |
| bus_en | input | 1 | Enable line, high opens a window, falling edge commits (asynchronous) |
| fcomp_in | input | 1 | Comparison-frequency test signal |
| divh_in | input | 1 | Divider output divided by two, test signal |
| ratio_pend | output | 17 | Pending divider ratio |
| ratio_load | output | 1 | One-cycle strobe to load `ratio_pend` |
| ref_sel | output | 4 | Reference divider code |
| pump_cur | output | 2 | Charge-pump current code |
| pump_mode | output | 2 | 00 normal, 01 sink, 10 source, 11 off |
| test_on | output | 1 | Test bit of the committed word |
| port1_on | output | 1 | Port 1 open-drain pull-down enable |
| port0_on | output | 1 | Port 0 open-drain pull-down enable |

## Verification
Full words with asymmetric field values show that every field lands in its own bit range rather than a shifted or mirrored one. Separate test-mode words cover each of the four port-bit codes, and toggling the two test inputs shows that ports track them only in the 11 code. Windows of 25 and 27 bits confirm that the count must match exactly. Bus clocks with enable low, and a check taken while enable is still high after a full word, separate shifting from committing.

// File: rtl/synth_ctrl_pkg.sv
package synth_ctrl_pkg;

    localparam int WORD_W  = 26;
    localparam int RATIO_W = 17;
    localparam int REF_W   = 4;
    localparam int CUR_W   = 2;

    typedef enum logic [1:0] {
        PM_NORMAL = 2'b00,
        PM_SINK   = 2'b01,
        PM_SOURCE = 2'b10,
        PM_OFF    = 2'b11
    } pump_mode_t;

    // Field layout of the serial word, first-sent bit at the top.
    typedef struct packed {
        logic               p1;
        logic               p0;
        logic               t0;
        logic [CUR_W-1:0]   cur;
        logic [REF_W-1:0]   refc;
        logic [RATIO_W-1:0] ratio;
    } ctrl_word_t;

endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] level_o
);

    for (genvar g = 0; g < N; g++) begin : g_line
        logic [STAGES-1:0] pipe;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe <= '0;
            end else begin
                pipe <= {pipe[STAGES-2:0], async_i[g]};
            end
        end

        assign level_o[g] = pipe[STAGES-1];
    end

endmodule

// File: rtl/word_rx.sv
module word_rx #(
    parameter int WORD_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdat,
    input  logic              sclk,
    input  logic              sen,
    output logic              commit_o,
    output logic [WORD_W-1:0] word_o
);

    localparam int CNT_W = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] OVER = CNT_W'(WORD_W + 1);

    typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_COMMIT, S_DROP} rx_state_t;

    rx_state_t         state, state_nx;
    logic              sclk_q, sen_q;
    logic              sclk_rise, sen_fall;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] shreg;

    assign sclk_rise = sclk & ~sclk_q;
    assign sen_fall  = ~sen & sen_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (sen) state_nx = S_SHIFT;
            S_SHIFT:  if (sen_fall) state_nx = (cnt == FULL) ? S_COMMIT : S_DROP;
            S_COMMIT: state_nx = S_IDLE;
            S_DROP:   state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Edge history, bit counter and shift register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            sen_q  <= 1'b0;
            cnt    <= '0;
            shreg  <= '0;
        end else begin
            sclk_q <= sclk;
            sen_q  <= sen;
            if (state == S_IDLE) begin
                cnt <= '0;
            end else if (state == S_SHIFT && sclk_rise && !sen_fall) begin
                shreg <= {shreg[WORD_W-2:0], sdat};
                if (cnt != OVER) cnt <= cnt + 1'b1;
            end
        end
    end

    // Outputs.
    always_comb begin
        commit_o = (state == S_COMMIT);
        word_o   = shreg;
    end

    p_commit_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> (cnt == FULL));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |=> $stable(shreg));

endmodule

// File: rtl/field_decode.sv
module field_decode
    import synth_ctrl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit_i,
    input  logic [WORD_W-1:0]  word_i,
    input  logic               fcomp_in,
    input  logic               divh_in,
    output logic [RATIO_W-1:0] ratio_pend,
    output logic               ratio_load,
    output logic [REF_W-1:0]   ref_sel,
    output logic [CUR_W-1:0]   pump_cur,
    output pump_mode_t         pump_mode,
    output logic               test_on,
    output logic               port1_on,
    output logic               port0_on
);

    ctrl_word_t creg;
    logic       observe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            creg       <= '0;
            ratio_load <= 1'b0;
        end else begin
            ratio_load <= commit_i;
            if (commit_i) creg <= ctrl_word_t'(word_i);
        end
    end

    assign observe = creg.t0 & creg.p1 & creg.p0;

    always_comb begin
        ratio_pend = creg.ratio;
        ref_sel    = creg.refc;
        pump_cur   = creg.cur;
        test_on    = creg.t0;
        if (!creg.t0) begin
            pump_mode = PM_NORMAL;
            port1_on  = creg.p1;
            port0_on  = creg.p0;
        end else begin
            unique case ({creg.p1, creg.p0})
                2'b00:   pump_mode = PM_SINK;
                2'b01:   pump_mode = PM_SOURCE;
                2'b10:   pump_mode = PM_OFF;
                default: pump_mode = PM_NORMAL;
            endcase
            port1_on = observe & fcomp_in;
            port0_on = observe & divh_in;
        end
    end

    p_load_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_load |=> !ratio_load);

    p_load_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> ratio_load);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> ($stable(ratio_pend) && $stable(ref_sel) && $stable(pump_cur)));

endmodule

// File: rtl/synth_ctrl_if.sv
module synth_ctrl_if
    import synth_ctrl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_data,
    input  logic               bus_clk,
    input  logic               bus_en,
    input  logic               fcomp_in,
    input  logic               divh_in,
    output logic [RATIO_W-1:0] ratio_pend,
    output logic               ratio_load,
    output logic [REF_W-1:0]   ref_sel,
    output logic [CUR_W-1:0]   pump_cur,
    output logic [1:0]         pump_mode,
    output logic               test_on,
    output logic               port1_on,
    output logic               port0_on
);

    logic [2:0]        lvl;
    logic              commit;
    logic [WORD_W-1:0] word;
    pump_mode_t        mode;

    bus_sync #(.N(3), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({bus_en, bus_clk, bus_data}),
        .level_o (lvl)
    );

    word_rx #(.WORD_W(WORD_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sdat     (lvl[0]),
        .sclk     (lvl[1]),
        .sen      (lvl[2]),
        .commit_o (commit),
        .word_o   (word)
    );

    field_decode u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_i   (commit),
        .word_i     (word),
        .fcomp_in   (fcomp_in),
        .divh_in    (divh_in),
        .ratio_pend (ratio_pend),
        .ratio_load (ratio_load),
        .ref_sel    (ref_sel),
        .pump_cur   (pump_cur),
        .pump_mode  (mode),
        .test_on    (test_on),
        .port1_on   (port1_on),
        .port0_on   (port0_on)
    );

    assign pump_mode = mode;

    p_normal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !test_on |-> (pump_mode == 2'b00));

    p_forced_ports_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (test_on && pump_mode != 2'b00) |-> (!port1_on && !port0_on));

endmodule

// File: tb/synth_ctrl_if_test.sv
module synth_ctrl_if_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_data = 1'b0, bus_clk = 1'b0, bus_en = 1'b0;
    logic        fcomp_in = 1'b0, divh_in = 1'b0;
    logic [16:0] ratio_pend;
    logic        ratio_load;
    logic [3:0]  ref_sel;
    logic [1:0]  pump_cur, pump_mode;
    logic        test_on, port1_on, port0_on;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [25:0] exp_q[$];
    logic [25:0] last_w = '0;

    always #10 clk = ~clk;

    synth_ctrl_if uut (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_clk(bus_clk),
        .bus_en(bus_en), .fcomp_in(fcomp_in), .divh_in(divh_in),
        .ratio_pend(ratio_pend), .ratio_load(ratio_load), .ref_sel(ref_sel),
        .pump_cur(pump_cur), .pump_mode(pump_mode), .test_on(test_on),
        .port1_on(port1_on), .port0_on(port0_on)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: each load strobe must match the oldest expected word.
    always @(negedge clk) begin
        if (rst_n && ratio_load) begin
            if (exp_q.size() == 0) begin
                check("R4 unexpected ratio_load", 32'd1, 32'd0);
            end else begin
                logic [25:0] w;
                w = exp_q.pop_front();
                check("R1 ratio_pend", {15'd0, ratio_pend}, {15'd0, w[16:0]});
                check("R1 ref_sel", {28'd0, ref_sel}, {28'd0, w[20:17]});
                check("R9 pump_cur", {30'd0, pump_cur}, {30'd0, w[22:21]});
                last_w = w;
            end
        end
    end

    task automatic open_win();
        bus_en = 1'b1;
        repeat (5) @(posedge clk);
    endtask

    task automatic close_win();
        repeat (5) @(posedge clk);
        bus_en = 1'b0;
        repeat (14) @(posedge clk);
    endtask

    task automatic shift_bits(input logic [25:0] w, input int n);
        for (int i = 0; i < n; i++) begin
            bus_data = (i < 26) ? w[25-i] : 1'b1;
            repeat (5) @(posedge clk);
            bus_clk = 1'b1;
            repeat (5) @(posedge clk);
            bus_clk = 1'b0;
        end
    endtask

    task automatic send_word(input logic [25:0] w, input int n);
        open_win();
        shift_bits(w, n);
        if (n == 26) exp_q.push_back(w);
        close_win();
    endtask

    // Expected port/pump state from the last accepted word (test inputs low).
    task automatic check_ctrl(input string req);
        logic [1:0] m;
        logic       e1, e0;
        @(negedge clk);
        if (!last_w[23]) begin
            m = 2'b00; e1 = last_w[25]; e0 = last_w[24];
        end else begin
            e1 = 1'b0; e0 = 1'b0;
            case (last_w[25:24])
                2'b00: m = 2'b01;
                2'b01: m = 2'b10;
                2'b10: m = 2'b11;
                default: m = 2'b00;
            endcase
        end
        check({req, " pump_mode"}, {30'd0, pump_mode}, {30'd0, m});
        check({req, " port1_on"}, {31'd0, port1_on}, {31'd0, e1});
        check({req, " port0_on"}, {31'd0, port0_on}, {31'd0, e0});
        check({req, " test_on"}, {31'd0, test_on}, {31'd0, last_w[23]});
    endtask

    task automatic check_held(input string req, input logic [25:0] w);
        @(negedge clk);
        check({req, " ratio held"}, {15'd0, ratio_pend}, {15'd0, w[16:0]});
        check({req, " ref held"}, {28'd0, ref_sel}, {28'd0, w[20:17]});
        check({req, " cur held"}, {30'd0, pump_cur}, {30'd0, w[22:21]});
        check({req, " port1 held"}, {31'd0, port1_on}, {31'd0, w[25] & ~w[23]});
    endtask

    function automatic logic [25:0] mk(input logic p1, input logic p0, input logic t0,
                                       input logic [1:0] c, input logic [3:0] r,
                                       input logic [16:0] ratio);
        return {p1, p0, t0, c, r, ratio};
    endfunction

    initial begin
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 ratio_pend", {15'd0, ratio_pend}, 32'd0);
        check("R10 ratio_load", {31'd0, ratio_load}, 32'd0);
        check("R10 ref_sel", {28'd0, ref_sel}, 32'd0);
        check("R10 pump_cur", {30'd0, pump_cur}, 32'd0);
        check("R10 pump_mode", {30'd0, pump_mode}, 32'd0);
        check("R10 ports", {30'd0, port1_on, port0_on}, 32'd0);

        // R1 R6 R9: normal words with asymmetric fields
        send_word(mk(1, 0, 0, 2'b10, 4'b0110, 17'h1A5C3), 26);
        check_ctrl("R6 p10");
        send_word(mk(0, 1, 0, 2'b01, 4'b1001, 17'h0F00F), 26);
        check_ctrl("R6 p01");
        send_word(mk(1, 1, 0, 2'b11, 4'b1110, 17'h10001), 26);
        check_ctrl("R6 p11");

        // R3: full word shifted, enable still high, nothing changes yet
        open_win();
        shift_bits(mk(0, 0, 0, 2'b00, 4'b0001, 17'h00ABC), 26);
        repeat (10) @(posedge clk);
        check_held("R3", last_w);
        exp_q.push_back(mk(0, 0, 0, 2'b00, 4'b0001, 17'h00ABC));
        close_win();
        check_ctrl("R3 after fall");

        // R4: short and long windows are discarded
        send_word(mk(1, 1, 1, 2'b11, 4'b1111, 17'h1FFFF), 25);
        check_held("R4 short", last_w);
        send_word(mk(1, 0, 1, 2'b10, 4'b1010, 17'h15555), 27);
        check_held("R4 long", last_w);

        // R2: clocks with enable low
        for (int i = 0; i < 30; i++) begin
            bus_data = i[0];
            repeat (4) @(posedge clk);
            bus_clk = 1'b1;
            repeat (4) @(posedge clk);
            bus_clk = 1'b0;
        end
        repeat (10) @(posedge clk);
        check_held("R2", last_w);
        check("R2 no pending", exp_q.size(), 32'd0);

        // R7 test-mode pump overrides
        send_word(mk(0, 0, 1, 2'b01, 4'b0011, 17'h00001), 26);
        check_ctrl("R7 sink");
        send_word(mk(0, 1, 1, 2'b10, 4'b0101, 17'h00002), 26);
        check_ctrl("R7 source");
        send_word(mk(1, 0, 1, 2'b11, 4'b1100, 17'h00004), 26);
        check_ctrl("R7 off");
        fcomp_in = 1'b1; divh_in = 1'b1;
        @(negedge clk);
        check("R7 ports ignore test inputs", {30'd0, port1_on, port0_on}, 32'd0);
        fcomp_in = 1'b0; divh_in = 1'b0;

        // R8 observation mode
        send_word(mk(1, 1, 1, 2'b00, 4'b1000, 17'h08000), 26);
        check_ctrl("R8 mode");
        fcomp_in = 1'b1; divh_in = 1'b0;
        @(negedge clk);
        check("R8 port1 fcomp", {30'd0, port1_on, port0_on}, 32'd2);
        fcomp_in = 1'b0; divh_in = 1'b1;
        @(negedge clk);
        check("R8 port0 divh", {30'd0, port1_on, port0_on}, 32'd1);
        divh_in = 1'b0;
        @(negedge clk);
        check("R8 both low", {30'd0, port1_on, port0_on}, 32'd0);

        // Back to normal mode
        send_word(mk(0, 1, 0, 2'b00, 4'b0000, 17'h12345), 26);
        check_ctrl("R6 return");

        repeat (5) @(posedge clk);
        check("R5 all loads seen", exp_q.size(), 32'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule